// File: doc/BRIEF.md
# Cache Region Maintenance Sequencer

This block is a register-driven engine that performs maintenance on a second-level cache. Software selects flush, invalidate, or flush-then-invalidate, and the scope is either the whole cache or an address window. Once the engine accepts a command it steps through every affected cache line. It presents one line address and one operation code per cycle toward the tag/data arrays, which take them with a ready handshake.

Software loads the window's upper bound first. Writing the window's lower bound launches the walk. A busy flag in the control word stays high from the launching write until the last line has been handed over, so software can poll for completion. The line size comes from a static configuration input. Address bits below the line size are dropped, so every line that touches the window is covered.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset the control word (word address 0) reads 0, busy is 0, and `line_valid` is 0.
- R2: The operation code for a window operation is built from control bit 9 (the low bit of field 11..9) and the mode bit at control bit 6. Bit 9 = 0 gives flush (`line_op` 01). Bit 9 = 1 with bit 6 = 0 gives invalidate (10). Bit 9 = 1 with bit 6 = 1 gives flush-then-invalidate (11). Control bits 11..10 have no effect on the operation.
- R3: A write to the upper-bound register (word address 1) only stores the value and starts nothing. A write to the lower-bound register (word address 2) stores the value and starts a window operation.
- R4: A window operation issues every line from the aligned lower bound up to and including the aligned upper bound, in ascending order. Address bits below the line size are ignored.
- R5: When the aligned upper bound is below the aligned lower bound, exactly one line, at the aligned lower bound, is issued.
- R6: Writing a value with bit 0 = 1 to word address 3 starts a whole-cache flush. Writing it to word address 4 starts a whole-cache invalidate, or a whole-cache flush-then-invalidate when control bit 6 is 1. A whole-cache operation issues lines 0 up to CACHE_BYTES minus one line. Writes with bit 0 = 0 to these addresses start nothing.
- R7: Busy (control bit 8) reads 1 on the first read after a launching write. It stays 1 until the last line is accepted and then reads 0, with no line left unissued.
- R8: While `line_ready` is 1, one line is issued per cycle. While it is 0, `line_valid`, `line_addr` and `line_op` hold steady.
- R9: Launching writes that arrive while busy are ignored. The lower-bound register keeps its value, and the running operation's lines and code are unchanged, even if the control word is rewritten.
- R10: `cfg_lsz` = 0 selects 128-byte lines and `cfg_lsz` = 1 selects 64-byte lines.
- R11: Control bits 0, 6 and 11..9 read back as written. Bit 8 cannot be written, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0 control, 1 upper bound, 2 lower bound, 3 whole flush, 4 whole invalidate) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr`, valid one cycle after the address is presented |
| cfg_lsz | input | 1 | Line size select: 0 = 128 bytes, 1 = 64 bytes; change only while idle |
| line_valid | output | 1 | A line command is presented |
| line_ready | input | 1 | The arrays accept the presented line command |
| line_addr | output | 32 | Line-aligned address of the command |
| line_op | output | 2 | 01 flush, 10 invalidate, 11 flush-then-invalidate |

## Verification
The bench targets how the mode bit and the field bit combine into an operation code. A design that decoded the wrong bit, or let bits 11..10 leak in, would send flush where invalidate was asked for. Unaligned bounds, and an upper bound below the lower bound, check for the off-by-one errors that would drop the final line or walk off toward the top of memory. A second launch, a control rewrite and a bound rewrite issued during a stalled walk catch a design that restarts or changes operation in flight. An immediate busy read after the trigger catches a design whose busy flag lags by a cycle and lets software believe the work is done.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [1:0] {
    MOP_NONE  = 2'b00,
    MOP_FLUSH = 2'b01,
    MOP_INV   = 2'b10,
    MOP_FINV  = 2'b11
  } maint_op_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_HI    = 3'd1;
  localparam logic [2:0] RA_LO    = 3'd2;
  localparam logic [2:0] RA_FLALL = 3'd3;
  localparam logic [2:0] RA_IVALL = 3'd4;

  localparam int CB_DIS  = 0;
  localparam int CB_MODE = 6;
  localparam int CB_BUSY = 8;
  localparam int CB_FLD  = 9;

  typedef struct packed {
    logic [2:0] fld;
    logic       mode;
    logic       dis;
  } ctrl_t;

endpackage

// File: rtl/cmc_align.sv
module cmc_align #(
  parameter int AW          = 32,
  parameter int SMALL_SHIFT = 6,
  parameter int LARGE_SHIFT = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic          lsz_i,
  output logic [AW-1:0] base_o
);
  localparam logic [AW-1:0] SMALL_MASK = ~((AW'(1) << SMALL_SHIFT) - AW'(1));
  localparam logic [AW-1:0] LARGE_MASK = ~((AW'(1) << LARGE_SHIFT) - AW'(1));

  generate
    if (SMALL_SHIFT == LARGE_SHIFT) begin : g_fixed
      assign base_o = addr_i & SMALL_MASK;
    end else begin : g_sel
      assign base_o = addr_i & (lsz_i ? SMALL_MASK : LARGE_MASK);
    end
  endgenerate
endmodule

// File: rtl/cmc_regs.sv
module cmc_regs
  import cmc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CACHE_BYTES = 2048
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            busy_i,
  output logic            go_o,
  output maint_op_e       go_op_o,
  output logic [AW-1:0]   go_first_o,
  output logic [AW-1:0]   go_last_o,
  output logic [DW-1:0]   rdata_o
);
  ctrl_t         ctrl_q;
  logic [AW-1:0] hi_q;
  logic [AW-1:0] lo_q;
  logic          is_lo, is_fl, is_iv;
  maint_op_e     inv_kind;
  logic [DW-1:0] rd_mux;

  assign is_lo = (addr_i == RA_LO);
  assign is_fl = (addr_i == RA_FLALL);
  assign is_iv = (addr_i == RA_IVALL);
  assign inv_kind = ctrl_q.mode ? MOP_FINV : MOP_INV;

  always_comb begin
    go_o       = we_i && !busy_i && (is_lo || ((is_fl || is_iv) && wdata_i[0]));
    go_first_o = is_lo ? wdata_i[AW-1:0] : '0;
    go_last_o  = is_lo ? hi_q : AW'(CACHE_BYTES - 1);
    if (is_lo)      go_op_o = ctrl_q.fld[0] ? inv_kind : MOP_FLUSH;
    else if (is_iv) go_op_o = inv_kind;
    else            go_op_o = MOP_FLUSH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CTRL: ctrl_q <= '{fld: wdata_i[CB_FLD+2:CB_FLD], mode: wdata_i[CB_MODE],
                             dis: wdata_i[CB_DIS]};
        RA_HI:   hi_q <= wdata_i[AW-1:0];
        RA_LO:   if (!busy_i) lo_q <= wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      RA_CTRL: begin
        rd_mux[CB_DIS]              = ctrl_q.dis;
        rd_mux[CB_MODE]             = ctrl_q.mode;
        rd_mux[CB_BUSY]             = busy_i;
        rd_mux[CB_FLD+2:CB_FLD]     = ctrl_q.fld;
      end
      RA_HI:   rd_mux[AW-1:0] = hi_q;
      RA_LO:   rd_mux[AW-1:0] = lo_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  // R9: a lower-bound write during a running walk leaves the stored bound alone
  a_r9_lo_kept: assert property (@(posedge clk) disable iff (rst)
    (we_i && busy_i && is_lo) |=> $stable(lo_q));

  // R3: an upper-bound write on an idle engine launches nothing
  a_r3_hi_no_launch: assert property (@(posedge clk) disable iff (rst)
    (we_i && !busy_i && addr_i == RA_HI) |=> !busy_i);
endmodule

// File: rtl/cmc_walker.sv
module cmc_walker
  import cmc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int SMALL_SHIFT = 6,
  parameter int LARGE_SHIFT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lsz_i,
  input  logic          go_i,
  input  maint_op_e     op_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          ready_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output maint_op_e     op_o
);
  localparam logic [AW-1:0] SMALL_BYTES = AW'(1) << SMALL_SHIFT;
  localparam logic [AW-1:0] LARGE_BYTES = AW'(1) << LARGE_SHIFT;

  logic [AW-1:0] step;
  logic [AW-1:0] first_al, last_al, last_fix;
  logic [AW-1:0] cur_q, last_q;
  logic          busy_q;
  maint_op_e     op_q;

  assign step = lsz_i ? SMALL_BYTES : LARGE_BYTES;

  cmc_align #(.AW(AW), .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)) u_al_first (
    .addr_i(first_i), .lsz_i(lsz_i), .base_o(first_al));
  cmc_align #(.AW(AW), .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)) u_al_last (
    .addr_i(last_i), .lsz_i(lsz_i), .base_o(last_al));

  assign last_fix = (last_al < first_al) ? first_al : last_al;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      op_q   <= MOP_NONE;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cur_q  <= first_al;
        last_q <= last_fix;
        op_q   <= op_i;
      end
    end else if (ready_i) begin
      if (cur_q == last_q) begin
        busy_q <= 1'b0;
        op_q   <= MOP_NONE;
      end else begin
        cur_q <= cur_q + step;
      end
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cur_q;
  assign op_o   = op_q;

  // R8: a stalled command holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ready_i) |=> (busy_q && $stable(cur_q) && $stable(op_q)));

  // R4: an accepted non-final line advances by exactly one line
  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ready_i && cur_q != last_q) |=> (busy_q && cur_q == $past(cur_q) + step));

  // R9: the operation code cannot change mid-walk
  a_r9_op_locked: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !(ready_i && cur_q == last_q)) |=> $stable(op_q));

  // R7: a launch raises busy on the following cycle
  a_r7_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (go_i && !busy_q) |=> busy_q);

  // R10: every issued address is line aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((cur_q & (step - AW'(1))) == '0));
endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cmc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int SMALL_SHIFT = 6,
  parameter int LARGE_SHIFT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cfg_lsz,
  output logic          line_valid,
  input  logic          line_ready,
  output logic [AW-1:0] line_addr,
  output logic [1:0]    line_op
);
  logic          go, busy;
  maint_op_e     go_op, cur_op;
  logic [AW-1:0] go_first, go_last;

  cmc_regs #(.AW(AW), .DW(DW), .CACHE_BYTES(CACHE_BYTES)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .busy_i(busy), .go_o(go), .go_op_o(go_op), .go_first_o(go_first),
    .go_last_o(go_last), .rdata_o(reg_rdata));

  cmc_walker #(.AW(AW), .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)) u_walk (
    .clk(clk), .rst(rst), .lsz_i(cfg_lsz), .go_i(go), .op_i(go_op),
    .first_i(go_first), .last_i(go_last), .ready_i(line_ready),
    .busy_o(busy), .addr_o(line_addr), .op_o(cur_op));

  assign line_valid = busy;
  assign line_op    = cur_op;

  // R1: no command leaves the block while reset is applied
  a_r1_quiet_reset: assert property (@(posedge clk) rst |=> !line_valid);
endmodule

// File: tb/cache_maint_seq_test.sv
module cache_maint_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_lsz = 1'b1;
  logic        line_valid;
  logic        line_ready = 1'b0;
  logic [31:0] line_addr;
  logic [1:0]  line_op;

  always #4 clk = ~clk;

  cache_maint_seq uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_lsz(cfg_lsz), .line_valid(line_valid),
    .line_ready(line_ready), .line_addr(line_addr), .line_op(line_op));

  typedef struct packed { logic [31:0] a; logic [1:0] op; } item_t;
  item_t q[$];
  int    vecs = 0;
  int    bad = 0;
  int    rdy_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  int    cyc = 0;
  int    last_hs = -10;
  int    consec = 0;
  string cur_req = "R4";
  bit    done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: line_ready = 1'b1;
      1: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; line_ready = lfsr[0]; end
      default: line_ready = 1'b0;
    endcase
  end

  // monitor: compare each accepted line against the scoreboard
  always @(negedge clk) begin
    item_t it;
    if (!rst && line_valid && line_ready) begin
      vecs++;
      if (cyc == last_hs + 1) consec++;
      last_hs = cyc;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected line addr=%h op=%b, expected none", cur_req, line_addr, line_op);
      end else begin
        it = q.pop_front();
        if (line_addr !== it.a || line_op !== it.op) begin
          bad++;
          $display("FAIL %s: line addr=%h op=%b, expected addr=%h op=%b",
                   cur_req, line_addr, line_op, it.a, it.op);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  function automatic logic [1:0] win_op(logic [31:0] ctrl);
    if (!ctrl[9]) return 2'b01;
    return ctrl[6] ? 2'b11 : 2'b10;
  endfunction

  task automatic push_win(logic [31:0] lo, logic [31:0] hi, logic [1:0] op);
    logic [31:0] lb, s, e;
    lb = cfg_lsz ? 32'd64 : 32'd128;
    s = lo & ~(lb - 1);
    e = hi & ~(lb - 1);
    if (e < s) e = s;
    for (logic [31:0] a = s; a <= e; a += lb) q.push_back('{a: a, op: op});
  endtask

  task automatic push_all(logic [1:0] op);
    logic [31:0] lb;
    lb = cfg_lsz ? 32'd64 : 32'd128;
    for (logic [31:0] a = 0; a < 32'd2048; a += lb) q.push_back('{a: a, op: op});
  endtask

  task automatic wait_idle(string req);
    logic [31:0] d;
    for (int i = 0; i < 600; i++) begin
      rd(3'd0, d);
      if (!d[8]) break;
    end
    chk({req, " busy cleared"}, {31'd0, d[8]}, 32'd0);
    chk({req, " all lines issued before busy clear"}, q.size(), 32'd0);
    q.delete();
  endtask

  task automatic win(string req, logic [31:0] ctrl, logic [31:0] lo, logic [31:0] hi);
    logic [31:0] d;
    cur_req = req;
    wr(3'd0, ctrl);
    wr(3'd1, hi);
    push_win(lo, hi, win_op(ctrl));
    wr(3'd2, lo);
    rd(3'd0, d);
    chk("R7 busy on first read after launch", {31'd0, d[8]}, 32'd1);
    wait_idle(req);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(3'd0, d);
    chk("R1 control word after reset", d, 32'd0);
    chk("R1 line_valid after reset", {31'd0, line_valid}, 32'd0);

    // R11 control readback
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d);
    chk("R11 control readback", d, 32'h0000_0E41);
    wr(3'd0, 32'h0);

    // R3: upper bound alone starts nothing
    cur_req = "R3";
    wr(3'd1, 32'h0000_4000);
    rd(3'd0, d);
    chk("R3 upper-bound write leaves busy low", {31'd0, d[8]}, 32'd0);
    rd(3'd1, d);
    chk("R3 upper bound stored", d, 32'h0000_4000);

    // R2/R4 window ops with 64-byte lines (R10)
    rdy_mode = 1;
    win("R2 flush window", 32'h0000_0000, 32'h0000_1010, 32'h0000_10C5);
    win("R2 invalidate window", 32'h0000_0200, 32'h0000_2000, 32'h0000_2100);
    win("R2 flush-invalidate window", 32'h0000_0240, 32'h0000_3033, 32'h0000_307F);
    win("R2 mode bit alone still flush", 32'h0000_0040, 32'h0000_5000, 32'h0000_5040);
    win("R2 bits 11..10 ignored", 32'h0000_0C40, 32'h0000_6000, 32'h0000_6080);
    win("R4 single unaligned line", 32'h0000_0200, 32'h0000_7005, 32'h0000_703F);
    win("R5 upper below lower", 32'h0000_0200, 32'h0000_8888, 32'h0000_8000);

    // R10 128-byte lines
    cfg_lsz = 1'b0;
    win("R10 128-byte window", 32'h0000_0200, 32'h0000_1234, 32'h0000_12FF);
    cur_req = "R10 whole flush 128";
    push_all(2'b01);
    wr(3'd3, 32'h1);
    wait_idle("R10 whole flush 128");
    cfg_lsz = 1'b1;

    // R6 whole-cache ops, R8 throughput with ready held high
    rdy_mode = 0;
    cur_req = "R6 whole flush";
    push_all(2'b01);
    consec = 0;
    wr(3'd3, 32'h1);
    wait_idle("R6 whole flush");
    chk("R8 one line per cycle", consec, 32'd31);
    wr(3'd0, 32'h0);
    cur_req = "R6 whole invalidate";
    push_all(2'b10);
    wr(3'd4, 32'h1);
    wait_idle("R6 whole invalidate");
    wr(3'd0, 32'h40);
    cur_req = "R6 whole flush-invalidate";
    push_all(2'b11);
    wr(3'd4, 32'h1);
    wait_idle("R6 whole flush-invalidate");
    cur_req = "R6 bit0 clear ignored";
    wr(3'd4, 32'h2);
    wr(3'd3, 32'h0);
    rd(3'd0, d);
    chk("R6 command with bit 0 clear ignored", {31'd0, d[8]}, 32'd0);
    chk("R6 no line after ignored command", {31'd0, line_valid}, 32'd0);

    // R9 / R8: launches during a stalled walk are ignored
    rdy_mode = 2;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0000_9040);
    cur_req = "R9";
    push_win(32'h0000_9000, 32'h0000_9040, 2'b01);
    wr(3'd2, 32'h0000_9000);
    wr(3'd2, 32'h0000_A000);
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h0000_0240);
    wr(3'd4, 32'h1);
    rd(3'd2, d);
    chk("R9 lower bound kept during walk", d, 32'h0000_9000);
    chk("R8 stalled address held", line_addr, 32'h0000_9000);
    chk("R8 stalled op held", {30'd0, line_op}, 32'd1);
    rdy_mode = 0;
    wait_idle("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule